// File: doc/BRIEF.md
# Decode-Stage Zero-Test Branch Resolver

This block settles conditional branches that test one register against zero while the branch still sits in the decode stage. It does not wait for the execute ALU. A dedicated reduction tree decides whether the register read from the register file is zero. A private adder forms the destination from the decode PC and the instruction's immediate. If the branch is taken, the front end is redirected in the same cycle, so a taken branch costs the single fetch slot that a jump costs.

A mode pin picks one of two architectural conventions:

- **Squash mode.** The instruction fetched behind a taken branch is turned into a no-op. The block asserts a kill for the fetch slot. In the next cycle it raises a flag that marks the instruction now in decode as a bubble.
- **Delay-slot mode.** The instruction after the branch always runs. No kill is ever produced, and the redirect still steers fetch to the target.

The decode slot behaves like the valid side of a valid/ready handshake:

- `dec_valid` marks a real instruction in decode.
- `dec_stall` is back-pressure from the hazard logic.
- A stalled or empty decode slot never produces a redirect or a kill. The branch is resolved only in the cycle it is free to leave decode.
- The outputs are combinational from the decode inputs. Only the bubble flag is registered.

Top module: `br_early_resolve`

## Requirements
- R1: With kind code 1 (branch-if-zero), a valid, unstalled branch redirects exactly when all 32 operand bits are zero.
- R2: With kind code 2 (branch-if-not-zero), a valid, unstalled branch redirects exactly when at least one operand bit is one.
- R3: Kind codes 0 (not a branch) and 3 (reserved) never redirect, whatever the operand.
- R4: The target output equals dec_pc + 4 + (sign-extended 16-bit offset shifted left by 2), modulo 2^32. This holds for negative offsets and across address wrap.
- R5: Redirect and kill stay low whenever dec_valid is low or dec_stall is high.
- R6: With slot_mode low, kill_fetch is high in exactly the cycles where redirect is high.
- R7: With slot_mode high, kill_fetch is never asserted, and taken branches still redirect.
- R8: decode_bubble is high in the cycle after a cycle with kill_fetch high, and low after any cycle without it.
- R9: While reset is held and in the first cycle after it, decode_bubble is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode slot holds a real instruction |
| dec_stall | input | 1 | Decode slot held by hazard back-pressure |
| dec_kind | input | 2 | Branch kind: 0 none, 1 if-zero, 2 if-not-zero, 3 reserved |
| dec_operand | input | 32 | Register value read for the test |
| dec_pc | input | 32 | Address of the instruction in decode |
| dec_offset | input | 16 | Signed word offset from the immediate field |
| slot_mode | input | 1 | 1 selects the one-delay-slot convention |
| redirect | output | 1 | Steer the next fetch to redirect_target |
| redirect_target | output | 32 | Computed branch destination |
| kill_fetch | output | 1 | Squash the instruction now being fetched |
| decode_bubble | output | 1 | Instruction now in decode is a squashed no-op |

## Verification
The bound checker watches every cycle for these properties:

- Non-branch kinds never redirect.
- A stalled or empty decode slot stays silent.
- The sense of each taken branch agrees with the operand's zero state.
- Kill follows redirect in squash mode and is absent in delay-slot mode.
- The bubble flag trails the kill by one cycle.

The exact arithmetic of the target needs the bench's scoreboard, which compares against an independent model. So does the behaviour for specific operands such as a lone top bit or a lone bottom bit, negative offsets and PC wrap. Mode switches between consecutive branches are also checked there, over directed and random traffic.

// File: rtl/br_pkg.sv
package br_pkg;

  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    BK_NONE = 2'd0,
    BK_EQZ  = 2'd1,
    BK_NEZ  = 2'd2,
    BK_RSVD = 2'd3
  } br_kind_e;

  localparam int INSN_BYTES = 4;
  localparam int INSN_SHIFT = 2;

endpackage

// File: rtl/br_zero_detect.sv
// Zero test built as a balanced binary OR tree. There is no subtractor.
// Nodes are kept in heap order: node i has children 2i+1 and 2i+2.
// The leaves start at index LEAVES-1. Leaves beyond WIDTH are tied low.
module br_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] operand,
  output logic             is_zero
);

  localparam int LEAVES = 1 << $clog2(WIDTH);
  localparam int NODES  = 2 * LEAVES - 1;

  logic [NODES-1:0] node;

  genvar j;
  generate
    for (j = 0; j < LEAVES; j++) begin : g_leaf
      if (j < WIDTH) begin : g_real
        assign node[LEAVES-1+j] = operand[j];
      end else begin : g_pad
        assign node[LEAVES-1+j] = 1'b0;
      end
    end
  endgenerate

  genvar i;
  generate
    for (i = 0; i < LEAVES - 1; i++) begin : g_inner
      assign node[i] = node[2*i+1] | node[2*i+2];
    end
  endgenerate

  assign is_zero = ~node[0];

endmodule

// File: rtl/br_target_adder.sv
// Branch destination adder, kept apart from the execute ALU.
module br_target_adder #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target
);
  import br_pkg::*;

  localparam int EXT_W = XLEN - OFF_W - INSN_SHIFT;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] byte_off;

  assign seq_pc   = pc + XLEN'(INSN_BYTES);
  assign byte_off = {{EXT_W{offset[OFF_W-1]}}, offset, {INSN_SHIFT{1'b0}}};
  assign target   = seq_pc + byte_off;

endmodule

// File: rtl/br_decide.sv
// Turns the kind and the zero flag into the redirect and kill controls.
module br_decide (
  input  logic             valid,
  input  logic             stall,
  input  br_pkg::br_kind_e kind,
  input  logic             is_zero,
  input  logic             slot_mode,
  output logic             redirect,
  output logic             kill
);
  import br_pkg::*;

  logic fire;
  logic cond;

  assign fire = valid & ~stall;

  always_comb begin
    unique case (kind)
      BK_EQZ:  cond = is_zero;
      BK_NEZ:  cond = ~is_zero;
      default: cond = 1'b0;
    endcase
  end

  assign redirect = fire & cond;
  assign kill     = redirect & ~slot_mode;

endmodule

// File: rtl/br_early_resolve.sv
module br_early_resolve #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dec_valid,
  input  logic                      dec_stall,
  input  logic [br_pkg::KIND_W-1:0] dec_kind,
  input  logic [XLEN-1:0]           dec_operand,
  input  logic [XLEN-1:0]           dec_pc,
  input  logic [OFF_W-1:0]          dec_offset,
  input  logic                      slot_mode,
  output logic                      redirect,
  output logic [XLEN-1:0]           redirect_target,
  output logic                      kill_fetch,
  output logic                      decode_bubble
);
  import br_pkg::*;

  logic     op_zero;
  br_kind_e kind;
  logic     bubble_q;

  assign kind = br_kind_e'(dec_kind);

  br_zero_detect #(.WIDTH(XLEN)) u_zero (
    .operand (dec_operand),
    .is_zero (op_zero)
  );

  br_target_adder #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
    .pc     (dec_pc),
    .offset (dec_offset),
    .target (redirect_target)
  );

  br_decide u_dec (
    .valid     (dec_valid),
    .stall     (dec_stall),
    .kind      (kind),
    .is_zero   (op_zero),
    .slot_mode (slot_mode),
    .redirect  (redirect),
    .kill      (kill_fetch)
  );

  // The squashed fetch reaches decode on the next edge.
  always_ff @(posedge clk) begin
    if (!rst_n) bubble_q <= 1'b0;
    else        bubble_q <= kill_fetch;
  end

  assign decode_bubble = bubble_q;

endmodule

// File: rtl/br_early_resolve_chk.sv
module br_early_resolve_chk #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      dec_valid,
  input logic                      dec_stall,
  input logic [br_pkg::KIND_W-1:0] dec_kind,
  input logic [XLEN-1:0]           dec_operand,
  input logic                      slot_mode,
  input logic                      redirect,
  input logic                      kill_fetch,
  input logic                      decode_bubble
);

  a_r1_eqz_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && dec_kind == 2'd1) |-> (dec_operand == '0));

  a_r2_nez_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && dec_kind == 2'd2) |-> (dec_operand != '0));

  a_r3_no_redirect_other: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_kind == 2'd0 || dec_kind == 2'd3) |-> !redirect);

  a_r5_gated_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid || dec_stall) |-> (!redirect && !kill_fetch));

  a_r6_kill_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_mode |-> (kill_fetch == redirect));

  a_r7_slot_no_kill: assert property (@(posedge clk) disable iff (!rst_n)
    slot_mode |-> !kill_fetch);

  a_r8_bubble_after_kill: assert property (@(posedge clk) disable iff (!rst_n)
    kill_fetch |=> decode_bubble);

  a_r8_no_spurious_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !kill_fetch |=> !decode_bubble);

endmodule

bind br_early_resolve br_early_resolve_chk #(.XLEN(XLEN), .OFF_W(OFF_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dec_valid     (dec_valid),
  .dec_stall     (dec_stall),
  .dec_kind      (dec_kind),
  .dec_operand   (dec_operand),
  .slot_mode     (slot_mode),
  .redirect      (redirect),
  .kill_fetch    (kill_fetch),
  .decode_bubble (decode_bubble)
);

// File: tb/tb_br_early_resolve.sv
`timescale 1ns/1ps
module tb_br_early_resolve;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic        dec_stall = 1'b0;
  logic [1:0]  dec_kind = 2'd0;
  logic [31:0] dec_operand = '0;
  logic [31:0] dec_pc = '0;
  logic [15:0] dec_offset = '0;
  logic        slot_mode = 1'b0;
  logic        redirect;
  logic [31:0] redirect_target;
  logic        kill_fetch;
  logic        decode_bubble;

  always #5 clk = ~clk;

  br_early_resolve dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .dec_valid       (dec_valid),
    .dec_stall       (dec_stall),
    .dec_kind        (dec_kind),
    .dec_operand     (dec_operand),
    .dec_pc          (dec_pc),
    .dec_offset      (dec_offset),
    .slot_mode       (slot_mode),
    .redirect        (redirect),
    .redirect_target (redirect_target),
    .kill_fetch      (kill_fetch),
    .decode_bubble   (decode_bubble)
  );

  typedef struct {
    logic        redir;
    logic        kill;
    logic        bubble;
    logic [31:0] target;
    string       rtag;
    string       ktag;
  } exp_t;

  exp_t        sb[$];
  int unsigned checks = 0;
  int unsigned failures = 0;
  logic        prev_kill = 1'b0;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic s, input logic [1:0] k,
                       input logic [31:0] op, input logic [31:0] pc,
                       input logic [15:0] off, input logic mode);
    exp_t e;
    logic cond;
    @(negedge clk);
    dec_valid = v; dec_stall = s; dec_kind = k; dec_operand = op;
    dec_pc = pc; dec_offset = off; slot_mode = mode;
    cond = (k == 2'd1 && op == 32'd0) || (k == 2'd2 && op != 32'd0);
    e.redir  = v && !s && cond;
    e.kill   = e.redir && !mode;
    e.bubble = prev_kill;
    e.target = pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
    if (!v || s)       e.rtag = "R5";
    else if (k == 2'd1) e.rtag = "R1";
    else if (k == 2'd2) e.rtag = "R2";
    else                e.rtag = "R3";
    e.ktag = mode ? "R7" : "R6";
    prev_kill = e.kill;
    sb.push_back(e);
  endtask

  // Monitor: samples 4 ns after the driving edge, before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(redirect == e.redir, e.rtag, "redirect", {31'd0, redirect}, {31'd0, e.redir});
        check(kill_fetch == e.kill, e.ktag, "kill_fetch", {31'd0, kill_fetch}, {31'd0, e.kill});
        check(decode_bubble == e.bubble, "R8", "decode_bubble",
              {31'd0, decode_bubble}, {31'd0, e.bubble});
        check(redirect_target == e.target, "R4", "target", redirect_target, e.target);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(decode_bubble == 1'b0, "R9", "bubble in reset", {31'd0, decode_bubble}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #4;
    check(decode_bubble == 1'b0, "R9", "bubble after reset", {31'd0, decode_bubble}, 32'd0);
    check(redirect == 1'b0, "R9", "redirect idle", {31'd0, redirect}, 32'd0);

    // R1: zero operand taken, lone top bit and lone bottom bit not taken
    apply(1, 0, 2'd1, 32'h0, 32'h0000_0100, 16'd50, 0);
    apply(1, 0, 2'd1, 32'h8000_0000, 32'h0000_0200, 16'd3, 0);
    apply(1, 0, 2'd1, 32'h0000_0001, 32'h0000_0300, 16'd3, 0);
    // R2: not-zero sense
    apply(1, 0, 2'd2, 32'h0000_0001, 32'h0000_0400, 16'hFFFF, 0);
    apply(1, 0, 2'd2, 32'h0, 32'h0000_0500, 16'd7, 0);
    // R3: kinds 0 and 3 with a zero operand
    apply(1, 0, 2'd0, 32'h0, 32'h0000_0600, 16'd1, 0);
    apply(1, 0, 2'd3, 32'h0, 32'h0000_0700, 16'd1, 0);
    // R4: most negative offset, and PC wrap
    apply(1, 0, 2'd1, 32'h0, 32'h0002_0000, 16'h8000, 0);
    apply(1, 0, 2'd2, 32'h5, 32'hFFFF_FFFC, 16'd2, 0);
    // R5: stalled and invalid slots stay silent
    apply(1, 1, 2'd1, 32'h0, 32'h0000_0800, 16'd4, 0);
    apply(0, 0, 2'd1, 32'h0, 32'h0000_0900, 16'd4, 0);
    // R7: delay-slot mode, taken branches back to back
    apply(1, 0, 2'd1, 32'h0, 32'h0000_0A00, 16'd8, 1);
    apply(1, 0, 2'd2, 32'h10, 32'h0000_0A04, 16'd8, 1);
    // R6/R8: mode switch to squash, then no kill
    apply(1, 0, 2'd1, 32'h0, 32'h0000_0B00, 16'd8, 0);
    apply(1, 0, 2'd0, 32'h0, 32'h0000_0B04, 16'd8, 0);
    apply(1, 0, 2'd0, 32'h0, 32'h0000_0B08, 16'd8, 0);

    // Random traffic across both modes
    for (int n = 0; n < 600; n++) begin
      logic [31:0] op;
      int unsigned sel;
      sel = $urandom % 4;
      if (sel == 0)      op = 32'h0;
      else if (sel == 1) op = 32'h1 << ($urandom % 32);
      else               op = $urandom;
      apply(($urandom % 8) != 0, ($urandom % 6) == 0, 2'($urandom),
            op, $urandom, 16'($urandom), 1'($urandom));
    end

    @(negedge clk);
    dec_valid = 1'b0;
    while (sb.size() > 0) @(negedge clk);
    #5;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule